// File: doc/BRIEF.md
# Configuration Port Access Arbiter

This block decides who may drive a shared device-configuration engine: a configuration port controlled by a remote host, or a requester inside the chip. The host side uses three wires. The host raises a request, the arbiter answers with a grant, and the arbiter can ask for the engine back through a release-request line. The arbiter never withdraws the host grant on its own initiative. It waits until the host lowers its request. The local side is a plain request and grant pair, with a done pulse that ends the local grant.

At power-up the engine belongs to the host port alone, until a stage-two-loaded input is seen. That indication is remembered until the next reset. After it has been seen, the arbiter passes the engine between the two sides and never grants both at once. When both sides are idle and request together, the host wins. A parameter selects a host-only build, in which the host grant is tied high and the release request is tied low.

Top module: `cfg_port_arb`

## Requirements
- R1: While rst_ni is low, host_gnt_o, host_rel_o and loc_gnt_o are all 0, and the arbiter restarts idle with the boot lock re-armed.
- R2: Until boot_done_i has been seen high since reset, loc_gnt_o stays 0 and host_rel_o stays 0, whatever loc_req_i does.
- R3: From idle, host_req_i high gives host_gnt_o = 1 on the next clock edge.
- R4: While the host is granted with no release pending, host_req_i low clears host_gnt_o on the next edge.
- R5: After boot, loc_req_i high while the host is granted sets host_rel_o = 1 on the next edge, and host_gnt_o stays 1.
- R6: host_rel_o and host_gnt_o stay 1 while host_req_i stays high, even if loc_req_i drops. Both clear on the edge after host_req_i goes low.
- R7: After boot, from idle with host_req_i low, loc_req_i high gives loc_gnt_o = 1 on the next edge.
- R8: loc_gnt_o holds until loc_done_i is high or loc_req_i is low at an edge, and it clears on that edge.
- R9: From idle, when host_req_i and loc_req_i are both high after boot, the host is granted and the local side is not.
- R10: host_gnt_o and loc_gnt_o are never 1 together.
- R11: With HOST_ONLY = 1, host_gnt_o is constantly 1, and host_rel_o and loc_gnt_o are constantly 0.
- R12: Once boot_done_i has been seen, it may fall again without re-locking the arbiter. Only reset re-locks it.
- R13: A host request that arrives during a local grant waits. The host is granted only after the local grant has ended and the arbiter is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boot_done_i | input | 1 | Stage-two design loaded; lifts the host-only lock |
| host_req_i | input | 1 | Host port wants the configuration engine |
| host_gnt_o | output | 1 | Engine granted to the host port |
| host_rel_o | output | 1 | Arbiter asks the host port to give the engine back |
| loc_req_i | input | 1 | Local requester wants the engine |
| loc_done_i | input | 1 | Local requester pulses this to finish |
| loc_gnt_o | output | 1 | Engine granted to the local requester |

## Verification
The hardest case to reach from the ports is the release handshake that runs while the boot flag is remembered but its input has already fallen. To get there, the stimulus first asserts boot_done_i for a single cycle during a local grant and then drops it. It then has the host take the engine after a tied request and raises a local request during host ownership. This holds host_rel_o across a cycle in which the local request is withdrawn. A mid-operation reset then shows that the lock is re-armed.

// File: rtl/cfg_arb_pkg.sv
package cfg_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE      = 2'd0,
    ARB_HOST_OWN  = 2'd1,
    ARB_HOST_REL  = 2'd2,
    ARB_LOCAL_OWN = 2'd3
  } arb_state_e;
endpackage

// File: rtl/cfg_arb_boot_lock.sv
module cfg_arb_boot_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic boot_done_i,
  output logic boot_ok_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          seen_q <= 1'b0;
    else if (boot_done_i) seen_q <= 1'b1;
  end

  // level is honoured in the cycle it arrives, then remembered
  assign boot_ok_o = seen_q | boot_done_i;
endmodule

// File: rtl/cfg_arb_fsm.sv
module cfg_arb_fsm
  import cfg_arb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       boot_ok_i,
  input  logic       host_req_i,
  input  logic       loc_req_i,
  input  logic       loc_done_i,
  output arb_state_e state_o
);
  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARB_IDLE: begin
        if (host_req_i)                  state_d = ARB_HOST_OWN;
        else if (boot_ok_i && loc_req_i) state_d = ARB_LOCAL_OWN;
      end
      ARB_HOST_OWN: begin
        if (!host_req_i)                 state_d = ARB_IDLE;
        else if (boot_ok_i && loc_req_i) state_d = ARB_HOST_REL;
      end
      // grant is only withdrawn once the host lets go
      ARB_HOST_REL: begin
        if (!host_req_i) state_d = ARB_IDLE;
      end
      ARB_LOCAL_OWN: begin
        if (loc_done_i || !loc_req_i) state_d = ARB_IDLE;
      end
      default: state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ARB_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/cfg_port_arb.sv
module cfg_port_arb
  import cfg_arb_pkg::*;
#(
  parameter bit HOST_ONLY = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic boot_done_i,
  input  logic host_req_i,
  output logic host_gnt_o,
  output logic host_rel_o,
  input  logic loc_req_i,
  input  logic loc_done_i,
  output logic loc_gnt_o
);
  logic       boot_ok;
  arb_state_e state;

  cfg_arb_boot_lock u_boot_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .boot_done_i (boot_done_i),
    .boot_ok_o   (boot_ok)
  );

  cfg_arb_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boot_ok_i  (boot_ok),
    .host_req_i (host_req_i),
    .loc_req_i  (loc_req_i),
    .loc_done_i (loc_done_i),
    .state_o    (state)
  );

  generate
    if (HOST_ONLY) begin : g_host_only
      logic unused_state;
      assign unused_state = ^state;
      assign host_gnt_o = 1'b1 | unused_state;
      assign host_rel_o = 1'b0;
      assign loc_gnt_o  = 1'b0;
    end else begin : g_shared
      assign host_gnt_o = (state == ARB_HOST_OWN) || (state == ARB_HOST_REL);
      assign host_rel_o = (state == ARB_HOST_REL);
      assign loc_gnt_o  = (state == ARB_LOCAL_OWN);
    end
  endgenerate
endmodule

// File: rtl/cfg_port_arb_chk.sv
module cfg_port_arb_chk #(
  parameter bit HOST_ONLY = 1'b0
) (
  input logic clk_i,
  input logic rst_ni,
  input logic boot_done_i,
  input logic host_req_i,
  input logic host_gnt_o,
  input logic host_rel_o,
  input logic loc_req_i,
  input logic loc_done_i,
  input logic loc_gnt_o
);
  logic boot_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          boot_seen_q <= 1'b0;
    else if (boot_done_i) boot_seen_q <= 1'b1;
  end

  // R10
  mutex_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_gnt_o && loc_gnt_o));

  // R2
  boot_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_gnt_o |-> boot_seen_q);

  // R5
  rel_needs_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rel_o |-> host_gnt_o);

  // R6
  rel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rel_o && host_req_i) |=> (host_rel_o && host_gnt_o));

  // R6
  rel_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rel_o && !host_req_i) |=> (!host_rel_o && !host_gnt_o));

  // R8
  loc_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_gnt_o && (loc_done_i || !loc_req_i)) |=> !loc_gnt_o);

  // R13
  loc_from_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(loc_gnt_o) |-> (!$past(host_gnt_o) && !$past(host_req_i)));

  generate
    if (HOST_ONLY) begin : g_ho
      // R11
      host_only_chk: assert property (@(posedge clk_i)
        host_gnt_o && !host_rel_o && !loc_gnt_o);
    end
  endgenerate
endmodule

bind cfg_port_arb cfg_port_arb_chk #(.HOST_ONLY(HOST_ONLY)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .boot_done_i (boot_done_i),
  .host_req_i  (host_req_i),
  .host_gnt_o  (host_gnt_o),
  .host_rel_o  (host_rel_o),
  .loc_req_i   (loc_req_i),
  .loc_done_i  (loc_done_i),
  .loc_gnt_o   (loc_gnt_o)
);

// File: tb/cfg_port_arb_tb.sv
`timescale 1ns/1ps
module cfg_port_arb_tb;
  logic clk = 1'b0;
  logic rst_ni;
  logic boot_done, host_req, loc_req, loc_done;
  logic host_gnt, host_rel, loc_gnt;
  logic ho_gnt, ho_rel, ho_lgnt;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  cfg_port_arb u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .boot_done_i(boot_done),
    .host_req_i(host_req), .host_gnt_o(host_gnt), .host_rel_o(host_rel),
    .loc_req_i(loc_req), .loc_done_i(loc_done), .loc_gnt_o(loc_gnt));

  cfg_port_arb #(.HOST_ONLY(1'b1)) u_dut_ho (
    .clk_i(clk), .rst_ni(rst_ni), .boot_done_i(boot_done),
    .host_req_i(host_req), .host_gnt_o(ho_gnt), .host_rel_o(ho_rel),
    .loc_req_i(loc_req), .loc_done_i(loc_done), .loc_gnt_o(ho_lgnt));

  // {host_req, loc_req, loc_done, boot_done, exp host_gnt, exp host_rel, exp loc_gnt}
  localparam int NV = 16;
  localparam logic [6:0] VEC [NV] = '{
    7'b0100_000, // R2 no local grant before boot
    7'b1100_100, // R3 host granted, R2 no release before boot
    7'b1100_100, // R2
    7'b0100_000, // R4
    7'b0101_001, // R7
    7'b0100_001, // R12 boot remembered, R8 held
    7'b1100_001, // R13 host waits
    7'b1110_000, // R8 done pulse
    7'b1100_100, // R9 host wins tie
    7'b1100_110, // R5
    7'b1000_110, // R6 held after local drop
    7'b0000_000, // R6 cleared
    7'b0100_001, // R7
    7'b0000_000, // R8 request dropped
    7'b1000_100, // R3
    7'b0000_000  // R4
  };

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_ni = 1'b0; boot_done = 1'b0; host_req = 1'b0; loc_req = 1'b0; loc_done = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {host_gnt, host_rel, loc_gnt}, 3'b000);
    check("R11 host-only in reset", {ho_gnt, ho_rel, ho_lgnt}, 3'b100);
    rst_ni = 1'b1;
    step();

    for (int i = 0; i < NV; i++) begin
      {host_req, loc_req, loc_done, boot_done} = VEC[i][6:3];
      step();
      check($sformatf("row %0d (R2..R13)", i), {host_gnt, host_rel, loc_gnt}, VEC[i][2:0]);
      check("R10 mutual exclusion", {1'b0, 1'b0, host_gnt & loc_gnt}, 3'b000);
      check("R11 host-only constant", {ho_gnt, ho_rel, ho_lgnt}, 3'b100);
    end

    // mid-grant reset re-arms the boot lock
    loc_req = 1'b1; host_req = 1'b0; loc_done = 1'b0; boot_done = 1'b0;
    step();
    check("R7 grant before reset", {host_gnt, host_rel, loc_gnt}, 3'b001);
    #0.5 rst_ni = 1'b0;
    #0.5;
    check("R1 async reset clears", {host_gnt, host_rel, loc_gnt}, 3'b000);
    @(negedge clk);
    rst_ni = 1'b1;
    step();
    step();
    check("R12 lock re-armed by reset", {host_gnt, host_rel, loc_gnt}, 3'b000);
    boot_done = 1'b1;
    step();
    check("R7 grant after new boot", {host_gnt, host_rel, loc_gnt}, 3'b001);
    boot_done = 1'b0; host_req = 1'b1;
    step();
    check("R13 host still waiting", {host_gnt, host_rel, loc_gnt}, 3'b001);
    loc_req = 1'b0;
    step();
    check("R8 local ends", {host_gnt, host_rel, loc_gnt}, 3'b000);
    step();
    check("R13 host granted after local", {host_gnt, host_rel, loc_gnt}, 3'b100);
    host_req = 1'b0;
    step();
    check("R4 host leaves", {host_gnt, host_rel, loc_gnt}, 3'b000);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule